// File: doc/BRIEF.md
# Addressable Control Latch Decoder

This block holds the system control bits that a CPU sets through two I/O ports. Each port feeds an 8-bit addressable latch. A single write changes exactly one bit of that latch: data bits 3:1 pick the bit and data bit 0 gives its new value. The other seven bits keep their values. The block turns the latch contents into named controls:

- a two-bit ROM bank whose bits come from both latches,
- screen flip,
- a three-bit colour bank,
- video enable,
- interrupt enable,
- video RAM bank select,
- coin counter drive,
- sample ROM bank select.

The block also contains the periodic interrupt source. A cycle counter produces a tick every `TICK_DIV` clocks; with a 50 MHz clock the default gives 120 ticks per second. While interrupt enable is set, a tick raises a level interrupt request. That request stays high until software clears interrupt enable. Clearing the enable removes any pending request on the same clock edge.

Top module: `ctl_latch_decoder`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, every control output and `irq_req` is 0.
- R2: A write to port 0x30 (low address byte) sets bit `io_data[3:1]` of latch A to `io_data[0]`. The other bits of latch A are unchanged. The new value appears on the outputs in the cycle after the write edge.
- R3: A write to port 0x31 sets bit `io_data[3:1]` of latch B to `io_data[0]` in the same way. It leaves latch A unchanged.
- R4: Only address bits 7:0 are decoded, so the upper address bits have no effect. A cycle that has `io_wr` low, or a low address byte other than 0x30 or 0x31, changes no control output.
- R5: Latch A drives these outputs: bit 1 is `flip_scr`, bits 4:2 are `color_bank` (bit 2 is the LSB), bit 5 is `video_en`, bit 6 is `irq_en` and bit 7 is `vram_bank`.
- R6: Latch B drives `coin_cnt` from bit 2 and `sample_bank` from bit 5.
- R7: `rom_bank[1]` is latch A bit 0 and `rom_bank[0]` is latch B bit 6.
- R8: `irq_req` rises only on a tick edge while `irq_en` is set. Ticks come every `TICK_DIV` cycles. Once raised, `irq_req` stays high as long as `irq_en` stays set.
- R9: `irq_req` is never high while `irq_en` is low. Writing 0 to the interrupt-enable bit lowers `irq_req` at the same edge where `irq_en` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| io_wr | input | 1 | I/O write strobe, one write per high cycle |
| io_addr | input | ADDR_W | I/O port address; only bits 7:0 are decoded |
| io_data | input | 8 | Write data: bits 3:1 select the bit, bit 0 is its value |
| rom_bank | output | 2 | ROM bank index |
| flip_scr | output | 1 | Screen flip |
| color_bank | output | 3 | Colour bank |
| video_en | output | 1 | Video enable |
| irq_en | output | 1 | Interrupt enable |
| vram_bank | output | 1 | Video RAM bank select |
| coin_cnt | output | 1 | Coin counter drive |
| sample_bank | output | 1 | Sample ROM bank select |
| irq_req | output | 1 | Level interrupt request |

## Verification
The assertions assume that `io_wr`, `io_addr` and `io_data` are stable at each rising edge, and that a write is one strobe cycle. They also assume the released reset stays released while they are checked. The bench changes every input only on the falling edge and holds it for a whole cycle. It mixes random addresses that hit both ports, with random upper bits, among addresses that miss. It turns the enable off before it asserts reset again.

// File: rtl/ctl_latch_pkg.sv
package ctl_latch_pkg;

  localparam int LATCH_BITS = 8;
  localparam int SEL_W      = $clog2(LATCH_BITS);
  localparam int COLOR_W    = 3;
  localparam int ROMB_W     = 2;
  localparam int NUM_LATCH  = 2;

  // bit positions inside latch A
  localparam int A_ROM_MSB  = 0;
  localparam int A_FLIP     = 1;
  localparam int A_COLOR_LO = 2;
  localparam int A_VIDEO    = 5;
  localparam int A_IRQ_EN   = 6;
  localparam int A_VRAM     = 7;

  // bit positions inside latch B
  localparam int B_COIN     = 2;
  localparam int B_SAMPLE   = 5;
  localparam int B_ROM_LSB  = 6;

  typedef struct packed {
    logic [ROMB_W-1:0]  rom_bank;
    logic               flip;
    logic [COLOR_W-1:0] color;
    logic               video;
    logic               irq_en;
    logic               vram;
    logic               coin;
    logic               sample;
  } ctl_fields_t;

endpackage

// File: rtl/ctl_reset_sync.sv
module ctl_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ctl_bit_latch.sv
module ctl_bit_latch #(
  parameter int          ADDR_W = 16,
  parameter int          DATA_W = 8,
  parameter int          BITS   = 8,
  parameter logic [7:0]  PORT   = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [BITS-1:0]   q,
  output logic [BITS-1:0]   q_nxt
);

  localparam int SEL_W = $clog2(BITS);

  logic             hit;
  logic [SEL_W-1:0] sel;
  logic             val;
  logic             unused_bits;

  assign hit = wr && (addr[7:0] == PORT);
  assign sel = data[SEL_W:1];
  assign val = data[0];
  assign unused_bits = ^{addr[ADDR_W-1:8], data[DATA_W-1:SEL_W+1]};

  for (genvar i = 0; i < BITS; i++) begin : g_bit
    localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
    logic bit_en;
    assign bit_en = hit && (sel == IDX);

    always_comb begin
      q_nxt[i] = bit_en ? val : q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= 1'b0;
      end else if (bit_en) begin
        q[i] <= q_nxt[i];
      end
    end
  end

endmodule

// File: rtl/ctl_tick_gen.sv
module ctl_tick_gen #(
  parameter int DIV = 416667
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ctl_field_decode.sv
module ctl_field_decode
  import ctl_latch_pkg::*;
(
  input  logic [LATCH_BITS-1:0] lat_a,
  input  logic [LATCH_BITS-1:0] lat_b,
  output ctl_fields_t           fields
);

  logic unused_b;
  assign unused_b = ^{lat_b[7], lat_b[4:3], lat_b[1:0]};

  always_comb begin
    fields.rom_bank = {lat_a[A_ROM_MSB], lat_b[B_ROM_LSB]};
    fields.flip     = lat_a[A_FLIP];
    fields.color    = lat_a[A_COLOR_LO +: COLOR_W];
    fields.video    = lat_a[A_VIDEO];
    fields.irq_en   = lat_a[A_IRQ_EN];
    fields.vram     = lat_a[A_VRAM];
    fields.coin     = lat_b[B_COIN];
    fields.sample   = lat_b[B_SAMPLE];
  end

endmodule

// File: rtl/ctl_latch_decoder.sv
module ctl_latch_decoder
  import ctl_latch_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter logic [7:0] PORT_A   = 8'h30,
  parameter logic [7:0] PORT_B   = 8'h31,
  parameter int         TICK_DIV = 416667
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_data,
  output logic [1:0]        rom_bank,
  output logic              flip_scr,
  output logic [2:0]        color_bank,
  output logic              video_en,
  output logic              irq_en,
  output logic              vram_bank,
  output logic              coin_cnt,
  output logic              sample_bank,
  output logic              irq_req
);

  logic                  rst_sync_n;
  logic [LATCH_BITS-1:0] lat_q   [NUM_LATCH];
  logic [LATCH_BITS-1:0] lat_nxt [NUM_LATCH];
  ctl_fields_t           fields;
  logic                  tick;
  logic                  en_nxt;
  logic                  irq_q;
  logic                  irq_d;
  logic                  unused_nxt;

  ctl_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar k = 0; k < NUM_LATCH; k++) begin : g_lat
    ctl_bit_latch #(
      .ADDR_W (ADDR_W),
      .DATA_W (8),
      .BITS   (LATCH_BITS),
      .PORT   ((k == 0) ? PORT_A : PORT_B)
    ) u_lat (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .wr    (io_wr),
      .addr  (io_addr),
      .data  (io_data),
      .q     (lat_q[k]),
      .q_nxt (lat_nxt[k])
    );
  end

  ctl_field_decode u_dec (
    .lat_a  (lat_q[0]),
    .lat_b  (lat_q[1]),
    .fields (fields)
  );

  ctl_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick)
  );

  // interrupt level: set by tick, dropped with the enable in the same edge
  assign en_nxt     = lat_nxt[0][A_IRQ_EN];
  assign unused_nxt = ^{lat_nxt[0][7], lat_nxt[0][5:0], lat_nxt[1]};

  always_comb begin
    irq_d = en_nxt & (irq_q | tick);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign rom_bank    = fields.rom_bank;
  assign flip_scr    = fields.flip;
  assign color_bank  = fields.color;
  assign video_en    = fields.video;
  assign irq_en      = fields.irq_en;
  assign vram_bank   = fields.vram;
  assign coin_cnt    = fields.coin;
  assign sample_bank = fields.sample;
  assign irq_req     = irq_q;

endmodule

// File: rtl/ctl_latch_decoder_chk.sv
module ctl_latch_decoder_chk #(
  parameter int         ADDR_W = 16,
  parameter logic [7:0] PORT_A = 8'h30,
  parameter logic [7:0] PORT_B = 8'h31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_data,
  input logic [1:0]        rom_bank,
  input logic              flip_scr,
  input logic [2:0]        color_bank,
  input logic              video_en,
  input logic              irq_en,
  input logic              vram_bank,
  input logic              coin_cnt,
  input logic              sample_bank,
  input logic              irq_req,
  input logic              tick
);

  logic hit_a;
  logic hit_b;
  logic unused_chk;
  logic [8:0] ctl_a;
  logic [2:0] ctl_b;

  assign hit_a = io_wr && (io_addr[7:0] == PORT_A);
  assign hit_b = io_wr && (io_addr[7:0] == PORT_B);
  assign unused_chk = ^{io_addr[ADDR_W-1:8], io_data[7:4]};
  assign ctl_a = {rom_bank[1], flip_scr, color_bank, video_en, irq_en, vram_bank};
  assign ctl_b = {rom_bank[0], coin_cnt, sample_bank};

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_en); // R9

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> (irq_req || !irq_en)); // R8

  AST_IRQ_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(tick)); // R8

  AST_NO_HIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_a || hit_b) |=> ($stable(ctl_a) && $stable(ctl_b))); // R4

  AST_B_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |=> $stable(ctl_a)); // R3

  AST_ROM_MSB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && io_data[3:1] == 3'd0) |=> (rom_bank[1] == $past(io_data[0]))); // R7

  AST_VIDEO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && io_data[3:1] == 3'd5) |=> (video_en == $past(io_data[0]))); // R5

endmodule

bind ctl_latch_decoder ctl_latch_decoder_chk #(
  .ADDR_W (ADDR_W),
  .PORT_A (PORT_A),
  .PORT_B (PORT_B)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .io_wr       (io_wr),
  .io_addr     (io_addr),
  .io_data     (io_data),
  .rom_bank    (rom_bank),
  .flip_scr    (flip_scr),
  .color_bank  (color_bank),
  .video_en    (video_en),
  .irq_en      (irq_en),
  .vram_bank   (vram_bank),
  .coin_cnt    (coin_cnt),
  .sample_bank (sample_bank),
  .irq_req     (irq_req),
  .tick        (tick)
);

// File: tb/ctl_latch_decoder_tb_top.sv
module ctl_latch_decoder_tb_top;

  localparam int ADDR_W = 16;
  localparam int DIV    = 37;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              io_wr = 1'b0;
  logic [ADDR_W-1:0] io_addr = '0;
  logic [7:0]        io_data = '0;
  logic [1:0]        rom_bank;
  logic              flip_scr;
  logic [2:0]        color_bank;
  logic              video_en;
  logic              irq_en;
  logic              vram_bank;
  logic              coin_cnt;
  logic              sample_bank;
  logic              irq_req;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit chk_on = 1'b0;
  logic [7:0] m_a = '0;
  logic [7:0] m_b = '0;
  logic prev_irq = 1'b0;

  always #10 clk = ~clk;

  ctl_latch_decoder #(.ADDR_W(ADDR_W), .TICK_DIV(DIV)) dut_i (
    .clk (clk), .rst_n (rst_n), .io_wr (io_wr), .io_addr (io_addr), .io_data (io_data),
    .rom_bank (rom_bank), .flip_scr (flip_scr), .color_bank (color_bank),
    .video_en (video_en), .irq_en (irq_en), .vram_bank (vram_bank),
    .coin_cnt (coin_cnt), .sample_bank (sample_bank), .irq_req (irq_req)
  );

  // reference latch contents, from R2/R3/R4
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_a <= '0;
      m_b <= '0;
    end else if (io_wr && io_addr[7:0] == 8'h30) begin
      m_a[io_data[3:1]] <= io_data[0];
    end else if (io_wr && io_addr[7:0] == 8'h31) begin
      m_b[io_data[3:1]] <= io_data[0];
    end
  end

  function automatic logic [1:0] exp_rom(input logic [7:0] a, input logic [7:0] b);
    return {a[0], b[6]};
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check("R5 flip_scr",    {7'd0, flip_scr},    {7'd0, m_a[1]});
      check("R5 color_bank",  {5'd0, color_bank},  {5'd0, m_a[4:2]});
      check("R5 video_en",    {7'd0, video_en},    {7'd0, m_a[5]});
      check("R5 irq_en",      {7'd0, irq_en},      {7'd0, m_a[6]});
      check("R5 vram_bank",   {7'd0, vram_bank},   {7'd0, m_a[7]});
      check("R6 coin_cnt",    {7'd0, coin_cnt},    {7'd0, m_b[2]});
      check("R6 sample_bank", {7'd0, sample_bank}, {7'd0, m_b[5]});
      check("R7 rom_bank",    {6'd0, rom_bank},    {6'd0, exp_rom(m_a, m_b)});
      if (!irq_en) check("R9 irq_req low without enable", {7'd0, irq_req}, 8'd0);
      if (prev_irq && irq_en) check("R8 irq_req held", {7'd0, irq_req}, 8'd1);
      prev_irq <= irq_req;
    end
  end

  task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_data = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic wait_irq(output int t);
    int n = 0;
    while (!irq_req && n < 3 * DIV) begin
      @(negedge clk);
      n++;
    end
    t = cyc;
    check("R8 irq_req raised", {7'd0, irq_req}, 8'd1);
  endtask

  initial begin
    int t1;
    int t2;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {rom_bank, flip_scr, color_bank, video_en, irq_en}, 8'd0);
    check("R1 reset outputs b", {4'd0, vram_bank, coin_cnt, sample_bank, irq_req}, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1'b1;
    check("R1 after release", {rom_bank, flip_scr, color_bank, video_en, irq_en}, 8'd0);

    // directed corners
    do_wr(16'hAB30, 8'h01);        // R4 upper bits ignored, R7 rom msb
    do_wr(16'h0031, 8'h0D);        // R7 rom lsb (bit 6)
    check("R7 rom_bank both", {6'd0, rom_bank}, 8'd3);
    do_wr(16'h0032, 8'h0B);        // R4 other port: no effect
    io_addr = 16'h0030; io_data = 8'h0B;
    @(negedge clk);                // R4 strobe low: no effect
    check("R4 no strobe", {7'd0, video_en}, 8'd0);
    do_wr(16'h0030, 8'h05);        // R2 color bit 2
    do_wr(16'h0030, 8'h09);        // color bit 4
    check("R2 color_bank", {5'd0, color_bank}, 8'd5);
    do_wr(16'h0031, 8'h05);        // R6 coin
    do_wr(16'h0031, 8'h0B);        // R6 sample
    check("R3 b leaves a", {5'd0, color_bank}, 8'd5);

    // interrupt period and clear
    do_wr(16'h0030, 8'h0D);
    wait_irq(t1);
    @(negedge clk);
    io_wr = 1'b1; io_addr = 16'h0030; io_data = 8'h0C;
    @(negedge clk);
    io_wr = 1'b0;
    check("R9 enable cleared", {7'd0, irq_en}, 8'd0);
    check("R9 irq dropped same edge", {7'd0, irq_req}, 8'd0);
    do_wr(16'h0030, 8'h0D);
    wait_irq(t2);
    check("R8 tick period", 8'(t2 - t1), 8'(DIV));

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      io_wr = ($urandom_range(0, 3) != 0);
      io_addr = ADDR_W'($urandom);
      case ($urandom_range(0, 4))
        0, 1:    io_addr[7:0] = 8'h30;
        2:       io_addr[7:0] = 8'h31;
        default: ;
      endcase
      io_data = 8'($urandom);
    end
    @(negedge clk);
    io_wr = 1'b0;
    @(negedge clk);
    chk_on = 1'b0;

    // asynchronous reset in mid cycle
    do_wr(16'h0030, 8'h0C);
    #5 rst_n = 1'b0;
    #1;
    check("R1 async reset", {rom_bank, flip_scr, color_bank, video_en, irq_en}, 8'd0);
    check("R1 async reset b", {4'd0, vram_bank, coin_cnt, sample_bank, irq_req}, 8'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule